// File: doc/BRIEF.md
# Pipeline ADC Digital Alignment and Correction

This block is the digital back end of a four-stage pipelined analog-to-digital converter. Three residue stages each resolve a 4-bit coarse code, and a final flash stage supplies a fourth 4-bit code. The stages run on alternating half-clock phases, so the four codes that belong to one analog sample arrive spread over two clock periods. The block holds each early code in a delay line until the last code of the same sample has arrived. It then merges the sixteen raw bits into one corrected 12-bit word.

Each residue stage is followed by a gain of 8, so every code overlaps the next one by one bit. The merge is a weighted sum in which each code is taken relative to a centred mid-scale decision. Because of this, a coarse decision that is off by one step near a threshold is cancelled by the stages that follow it. The result is clamped to the 12-bit range, flagged when clamped, and passed through two register levels. The output bus therefore changes only on the rising edge of the sampling clock.

Top module: `pipe_adc_backend`

## Requirements
- R1: The stage codes of one sample are applied in half-cycle order: stage 1 (bits [3:0] of `stage_codes`) before rising edge E, stage 2 (bits [7:4]) before the falling edge that follows E, stage 3 (bits [11:8]) before rising edge E+1, and the final flash code (bits [15:12]) before the falling edge that follows E+1. The corrected word for that sample appears after rising edge E+3.
- R2: For arbitrary codes c1..c4, the merged value is 512·c1 + 64·c2 + 8·c3 + c4 − 2340, where 2340 is the centring offset 4·(512+64+8+1).
- R3: Codes derived from an ideal value V, with any stage decision moved by ±1 code step while its residue stays inside the redundancy range, yield exactly V.
- R4: The output is offset binary: 0 is negative full scale and 4095 is positive full scale, and both ideal extremes are reproduced exactly.
- R5: A merged value below 0 gives an output of 0 with `over_range` high for that word.
- R6: A merged value above 4095 gives an output of 4095 with `over_range` high for that word.
- R7: `over_range` is low for every word whose merged value lies in 0..4095, including the values 0 and 4095 themselves, and it is never high while `word_valid` is low.
- R8: After the first word, a new word for a new sample is presented on every rising edge.
- R9: While the synchronous active-high `rst` is sampled high, the delay line and both output register levels clear, and `sample_word`, `word_valid` and `over_range` read 0 after the next rising edge.
- R10: After reset is released, `word_valid` and `sample_word` stay 0 for the first three rising edges. `word_valid` then rises with the first fully aligned word and stays high.
- R11: `sample_word` does not change between one rising edge and the falling edge that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock. Stages 1 and 3 are captured on the rising edge, stages 2 and 4 on the falling edge. |
| rst | input | 1 | Synchronous active-high reset. |
| stage_codes | input | 16 | Four 4-bit stage codes. Stage 1 is in the lowest nibble and the final flash stage in the highest. |
| sample_word | output | 12 | Corrected offset-binary sample. |
| word_valid | output | 1 | High once the first aligned sample has reached the output. |
| over_range | output | 1 | High for a word that was clamped to 0 or 4095. |

## Verification
The bench builds the block with its default parameters: a 4-bit code width and four stages. This gives a 12-bit word, a centring offset of 2340, and delay lines of depth two, one, one and zero, so the zero-depth path from the last falling-edge capture straight into the merge is exercised. The stimulus mixes codes derived from random ideal values with threshold-bounded ±1 decision errors, raw arbitrary codes, and codes placed exactly on and just beyond both clamp limits. Each word is compared against an expected value computed from the sample that was injected three edges earlier.

// File: rtl/adc_align_pkg.sv
`timescale 1ns/1ps
package adc_align_pkg;

  // Rising edges from the first-stage capture until all codes of a sample are aligned
  function automatic int align_edges(input int stages);
    return (stages + 1) / 2;
  endfunction

  // Rising-edge registers needed behind the capture of stage idx
  function automatic int stage_depth(input int idx, input int stages);
    if (idx % 2 == 0) return align_edges(stages) - idx / 2;
    else              return align_edges(stages) - (idx + 1) / 2;
  endfunction

  // Sum of mid-scale decisions across all stage weights
  function automatic int merge_offset(input int code_w, input int stages);
    int acc;
    acc = 0;
    for (int i = 0; i < stages; i++) acc += (1 << ((code_w - 1) * i));
    return acc * (1 << (code_w - 2));
  endfunction

endpackage

// File: rtl/delay_chain.sv
`timescale 1ns/1ps
module delay_chain #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);
  logic [WIDTH-1:0] tap [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
    end else begin
      tap[0] <= src;
      for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
    end
  end

  assign dst = tap[DEPTH-1];
endmodule

// File: rtl/stage_delay.sv
`timescale 1ns/1ps
module stage_delay #(
  parameter int CODE_W     = 4,
  parameter bit LATE_PHASE = 1'b0,
  parameter int DEPTH      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out
);
  generate
    if (LATE_PHASE) begin : g_late
      logic [CODE_W-1:0] half_q;
      always_ff @(negedge clk) begin
        if (rst) half_q <= '0;
        else     half_q <= code_in;
      end
      if (DEPTH == 0) begin : g_direct
        assign code_out = half_q;
      end else begin : g_chain
        delay_chain #(.WIDTH(CODE_W), .DEPTH(DEPTH)) u_chain (
          .clk(clk), .rst(rst), .src(half_q), .dst(code_out)
        );
      end
    end else begin : g_early
      delay_chain #(.WIDTH(CODE_W), .DEPTH(DEPTH)) u_chain (
        .clk(clk), .rst(rst), .src(code_in), .dst(code_out)
      );
    end
  endgenerate
endmodule

// File: rtl/code_merge.sv
`timescale 1ns/1ps
module code_merge
  import adc_align_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int NUM_STAGES = 4,
  localparam int GAIN_W    = CODE_W - 1,
  localparam int OUT_W     = GAIN_W * NUM_STAGES
) (
  input  logic [NUM_STAGES*CODE_W-1:0] codes,
  output logic [OUT_W-1:0]             word,
  output logic                         clamped
);
  localparam int SUM_W  = OUT_W + CODE_W + 1;
  localparam int OFFSET = merge_offset(CODE_W, NUM_STAGES);
  localparam logic signed [SUM_W-1:0] OFFS  = SUM_W'(OFFSET);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << OUT_W) - 1);

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = -OFFS;
    for (int s = 0; s < NUM_STAGES; s++) begin
      acc = acc + ($signed({{(SUM_W-CODE_W){1'b0}}, codes[s*CODE_W +: CODE_W]})
                   <<< (GAIN_W * (NUM_STAGES - 1 - s)));
    end
    if (acc < 0) begin
      word    = '0;
      clamped = 1'b1;
    end else if (acc > MAX_S) begin
      word    = '1;
      clamped = 1'b1;
    end else begin
      word    = acc[OUT_W-1:0];
      clamped = 1'b0;
    end
  end
endmodule

// File: rtl/out_buffer.sv
`timescale 1ns/1ps
module out_buffer #(
  parameter int OUT_W = 12,
  parameter int ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] word_in,
  input  logic             clamp_in,
  output logic [OUT_W-1:0] data_q,
  output logic             ovr_q,
  output logic             valid_q
);
  localparam int CNT_W = $clog2(ALIGN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ALIGN);

  logic [CNT_W-1:0] fill_cnt;
  logic [OUT_W-1:0] hold_word;
  logic             hold_ovr;
  logic             hold_valid;
  logic             aligned;

  assign aligned = (fill_cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt   <= '0;
      hold_word  <= '0;
      hold_ovr   <= 1'b0;
      hold_valid <= 1'b0;
      data_q     <= '0;
      ovr_q      <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      if (!aligned) fill_cnt <= fill_cnt + 1'b1;
      hold_valid <= aligned;
      hold_word  <= aligned ? word_in : '0;
      hold_ovr   <= aligned & clamp_in;
      data_q     <= hold_word;
      ovr_q      <= hold_ovr;
      valid_q    <= hold_valid;
    end
  end

  // R7: a clamp flag only accompanies a valid word
  a_r7_ovr_only_valid: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> valid_q);

  // R5/R6: a clamped word sits on one of the rails
  a_r5_ovr_at_rail: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> (data_q == '0 || data_q == '1));

  // R10: once valid, the output stays valid
  a_r10_valid_holds: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

  // R10: no data leaks out before the first aligned word
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (data_q == '0 && !ovr_q));

  // R9: the edge after a reset cycle leaves every output cleared
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_q && !ovr_q && data_q == '0));
endmodule

// File: rtl/pipe_adc_backend.sv
`timescale 1ns/1ps
module pipe_adc_backend
  import adc_align_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int NUM_STAGES = 4,
  localparam int OUT_W     = (CODE_W - 1) * NUM_STAGES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
  output logic [OUT_W-1:0]             sample_word,
  output logic                         word_valid,
  output logic                         over_range
);
  localparam int ALIGN = align_edges(NUM_STAGES);

  logic [NUM_STAGES*CODE_W-1:0] aligned_codes;
  logic [OUT_W-1:0]             merged_word;
  logic                         merged_clamp;

  generate
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      stage_delay #(
        .CODE_W    (CODE_W),
        .LATE_PHASE(s % 2 == 1),
        .DEPTH     (stage_depth(s, NUM_STAGES))
      ) u_delay (
        .clk     (clk),
        .rst     (rst),
        .code_in (stage_codes[s*CODE_W +: CODE_W]),
        .code_out(aligned_codes[s*CODE_W +: CODE_W])
      );
    end
  endgenerate

  code_merge #(.CODE_W(CODE_W), .NUM_STAGES(NUM_STAGES)) u_merge (
    .codes  (aligned_codes),
    .word   (merged_word),
    .clamped(merged_clamp)
  );

  out_buffer #(.OUT_W(OUT_W), .ALIGN(ALIGN)) u_out (
    .clk     (clk),
    .rst     (rst),
    .word_in (merged_word),
    .clamp_in(merged_clamp),
    .data_q  (sample_word),
    .ovr_q   (over_range),
    .valid_q (word_valid)
  );
endmodule

// File: tb/pipe_adc_backend_test.sv
`timescale 1ns/1ps
module pipe_adc_backend_test;
  localparam int NS = 400;
  localparam real PER = 5.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  c1 = '0, c2 = '0, c3 = '0, c4 = '0;
  logic [15:0] stage_codes;
  logic [11:0] sample_word;
  logic        word_valid, over_range;

  assign stage_codes = {c4, c3, c2, c1};
  always #(PER/2) clk = ~clk;

  pipe_adc_backend uut (
    .clk(clk), .rst(rst), .stage_codes(stage_codes),
    .sample_word(sample_word), .word_valid(word_valid), .over_range(over_range)
  );

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  logic [3:0] sc [0:NS+3][0:3];
  int    exp_v [0:NS+3];
  bit    exp_o [0:NS+3];
  string tag   [0:NS+3];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Ideal value -> stage codes with bounded +-1 decision errors
  task automatic from_ideal(input int k, input int v);
    int r, w, q, rem, e, code;
    r = v;
    w = 512;
    for (int s = 0; s < 3; s++) begin
      q   = (r >= 0) ? r / w : -((-r + w - 1) / w);
      rem = r - q * w;
      e   = int'($urandom_range(2)) - 1;
      if (e == 1 && rem < w / 2) e = 0;
      if (e == -1 && rem >= w / 2) e = 0;
      code = q + 4 + e;
      if (code < 0 || code > 15) begin e = 0; code = q + 4; end
      sc[k][s] = code[3:0];
      r = r - (code - 4) * w;
      w = w / 8;
    end
    sc[k][3] = 4'(r + 4);
    exp_v[k] = v;
    exp_o[k] = 1'b0;
  endtask

  // Arbitrary codes -> expected from the merge rule and clamp limits
  task automatic from_codes(input int k, input int a, input int b, input int c, input int d);
    int raw;
    sc[k][0] = 4'(a); sc[k][1] = 4'(b); sc[k][2] = 4'(c); sc[k][3] = 4'(d);
    raw = 512 * a + 64 * b + 8 * c + d - 2340;
    if (raw < 0)         begin exp_v[k] = 0;    exp_o[k] = 1'b1; end
    else if (raw > 4095) begin exp_v[k] = 4095; exp_o[k] = 1'b1; end
    else                 begin exp_v[k] = raw;  exp_o[k] = 1'b0; end
  endtask

  initial begin
    for (int k = 0; k <= NS + 3; k++) begin
      case (k % 16)
        0:  begin from_codes(k, 0, 0, 0, 0);     tag[k] = "R5"; end
        5:  begin from_codes(k, 15, 15, 15, 15); tag[k] = "R6"; end
        9:  begin from_ideal(k, 0);              tag[k] = "R4"; end
        12: begin from_ideal(k, 4095);           tag[k] = "R4"; end
        3:  begin
              from_codes(k, int'($urandom_range(15)), int'($urandom_range(15)),
                            int'($urandom_range(15)), int'($urandom_range(15)));
              tag[k] = "R2";
            end
        14: begin
              case ((k / 16) % 4)
                0: begin from_codes(k, 4, 4, 4, 3);     tag[k] = "R5"; end
                1: begin from_codes(k, 12, 4, 4, 4);    tag[k] = "R6"; end
                2: begin from_codes(k, 11, 11, 11, 11); tag[k] = "R7"; end
                default: begin from_codes(k, 4, 4, 4, 4); tag[k] = "R7"; end
              endcase
            end
        default: begin from_ideal(k, int'($urandom_range(4095))); tag[k] = "R3"; end
      endcase
    end

    repeat (4) @(posedge clk);
    #1;
    chk(sample_word == 0, "R9 reset word", int'(sample_word), 0);
    chk(word_valid == 0, "R9 reset valid", int'(word_valid), 0);
    chk(over_range == 0, "R9 reset flag", int'(over_range), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    c1 = sc[0][0];

    for (int k = 0; k <= NS + 2; k++) begin
      logic [11:0] seen;
      @(posedge clk); #1;
      c2 = sc[k][1];
      c4 = (k > 0) ? sc[k-1][3] : 4'd0;
      #1;
      seen = sample_word;
      if (k < 3) begin
        chk(word_valid == 0, "R10 valid before fill", int'(word_valid), 0);
        chk(sample_word == 0, "R10 word before fill", int'(sample_word), 0);
        chk(over_range == 0, "R7 flag before fill", int'(over_range), 0);
      end else begin
        chk(word_valid == 1, "R10/R8 valid", int'(word_valid), 1);
        chk(int'(sample_word) == exp_v[k-3], {tag[k-3], " R1 word"}, int'(sample_word), exp_v[k-3]);
        chk(over_range == exp_o[k-3], {tag[k-3], " over_range"}, int'(over_range), int'(exp_o[k-3]));
      end
      @(negedge clk); #1;
      chk(sample_word == seen, "R11 stable word", int'(sample_word), int'(seen));
      c1 = sc[k+1][0];
      c3 = sc[k][2];
    end

    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    chk(sample_word == 0, "R9 late reset word", int'(sample_word), 0);
    chk(word_valid == 0, "R9 late reset valid", int'(word_valid), 0);
    chk(over_range == 0, "R9 late reset flag", int'(over_range), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule